// File: doc/BRIEF.md
# Framed Transmit Queue Ingress

This block is the write side of a transmit packet queue. A system-side source presents one 32-bit packet word per clock, with four byte-lane valid bits and start and end markers. The source holds an active-low write enable low for as long as it has words to deliver, and may place several whole packets back to back under one assertion. Each accepted word is stored with its lane bits and both markers as a single 38-bit queue entry. A downstream consumer drains the entries in arrival order through a valid/ready read port.

The block checks every offered word on the way in. A frame-boundary word whose lane bits are all zero is refused. A start marker that arrives while a packet is still open is flagged, and so is an end marker that arrives with no packet open. A word offered while the queue is full is discarded. Each of these events sets its own sticky error flag, which stays set until an explicit clear. Two active-low fill indicators compare the registered fill level against two independent thresholds, so the source can throttle itself.

Top module: `txq_ingress`

## Requirements
- R1: When `wr_en_n` is low and the word is neither refused (R4) nor lost to overflow (R6), it is stored at that rising edge. Consecutive packets under one continuous enable are all stored. When `wr_en_n` is high, nothing is stored.
- R2: An entry is laid out as data in bits 37:6, lane bits in 5:2, start marker in bit 1 and end marker in bit 0, all copied unchanged. Lane bit 3 qualifies data bits 31:24, bit 2 bits 23:16, bit 1 bits 15:8 and bit 0 bits 7:0.
- R3: A word that carries neither marker is stored with any lane pattern, including all zeros, and raises no flag.
- R4: An enabled word with either marker set and lane bits 4'b0000 is not stored and sets `lane_err`.
- R5: A stored word with a start marker while a packet is open, or with an end marker but no start marker while no packet is open, sets `frame_err` and is still stored. A word carrying both markers is a complete one-word packet. An end marker closes the open packet and a start marker alone opens one.
- R6: A legal enabled word offered while the queue holds DEPTH entries is discarded and sets `ovf_err`, even if an entry is read in the same cycle.
- R7: Each error flag stays set until `err_clr` is high at a rising edge. If a new error occurs in that same cycle, the flag stays set.
- R8: `rd_valid` is high whenever the queue is not empty. An entry leaves on a rising edge where `rd_valid` and `rd_ready` are both high, and entries leave in the order they were stored.
- R9: `mark_a_n` (`mark_b_n`) goes low when the fill level is greater than `thr_a` (`thr_b`) and high otherwise. Each follows the registered level one clock later. A write and a read in the same cycle leave the level unchanged.
- R10: After reset the queue is empty, all three flags are low and both marks are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 32 | Packet word |
| wr_lanes | input | 4 | Byte-lane valid bits for `wr_data` |
| wr_sof | input | 1 | First word of a packet |
| wr_eof | input | 1 | Last word of a packet |
| err_clr | input | 1 | Clears the sticky error flags |
| thr_a | input | LVLW | Threshold for `mark_a_n` |
| thr_b | input | LVLW | Threshold for `mark_b_n` |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_valid | output | 1 | Head entry available |
| rd_entry | output | 38 | Head entry {data, lanes, sof, eof} |
| mark_a_n | output | 1 | Fill above `thr_a`, active low |
| mark_b_n | output | 1 | Fill above `thr_b`, active low |
| lane_err | output | 1 | Sticky: boundary word with no valid lane |
| frame_err | output | 1 | Sticky: marker out of sequence |
| ovf_err | output | 1 | Sticky: write lost to a full queue |

## Verification
Assertions check on every cycle that the level never passes DEPTH and that no write reaches storage while it is full. They also check that a refused boundary word always raises `lane_err`, that set flags persist until cleared, and that every mark transition agrees with the previous cycle's level and threshold. Only the bench scenarios can show the stored contents and their order. The same goes for the exact cycle on which each mark moves, the effect of a simultaneous read on a full queue, and the way the open-packet state evolves through a mixed stream of legal and faulty words.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = WORD_W / 8;
  localparam int unsigned ENTRY_W = WORD_W + LANES + 2;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [LANES-1:0]  lanes;
    logic              sof;
    logic              eof;
  } txq_entry_t;

  // A frame boundary word must carry at least one valid lane.
  function automatic logic lanes_bad(logic [LANES-1:0] l, logic s, logic e);
    return (s || e) && (l == '0);
  endfunction

  // Marker out of sequence with respect to the open-packet state.
  function automatic logic frame_bad(logic open, logic s, logic e);
    return (s && open) || (e && !s && !open);
  endfunction

  function automatic logic frame_open_next(logic open, logic s, logic e);
    if (e) return 1'b0;
    if (s) return 1'b1;
    return open;
  endfunction

  function automatic logic above(logic [31:0] lvl, logic [31:0] thr);
    return lvl > thr;
  endfunction
endpackage

// File: rtl/txq_frame_check.sv
module txq_frame_check
  import txq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_n,
  input  logic             sof,
  input  logic             eof,
  input  logic [LANES-1:0] lanes,
  input  logic             full,
  input  logic             err_clr,
  output logic             store,
  output logic             lane_err,
  output logic             frame_err,
  output logic             ovf_err
);
  logic attempt, lane_hit, ovf_hit, frame_hit, open_q;

  assign attempt   = !wr_en_n;
  assign lane_hit  = attempt && lanes_bad(lanes, sof, eof);
  assign ovf_hit   = attempt && !lane_hit && full;
  assign store     = attempt && !lane_hit && !full;
  assign frame_hit = store && frame_bad(open_q, sof, eof);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      lane_err  <= 1'b0;
      frame_err <= 1'b0;
      ovf_err   <= 1'b0;
    end else begin
      if (store) open_q <= frame_open_next(open_q, sof, eof);
      if (lane_hit)       lane_err <= 1'b1;
      else if (err_clr)   lane_err <= 1'b0;
      if (frame_hit)      frame_err <= 1'b1;
      else if (err_clr)   frame_err <= 1'b0;
      if (ovf_hit)        ovf_err <= 1'b1;
      else if (err_clr)   ovf_err <= 1'b0;
    end
  end

  // R4
  lane_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && (sof || eof) && lanes == '0) |=> lane_err);

  // R7
  frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clr) |=> frame_err);

  // R7
  lane_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_err && !err_clr) |=> lane_err);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !err_clr) |=> ovf_err);
endmodule

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter  int unsigned DEPTH = 512,
  localparam int unsigned LVLW  = $clog2(DEPTH + 1),
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_entry,
  input  logic               pop_ready,
  output logic               full,
  output logic               rd_valid,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic [LVLW-1:0]    level
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wp, rp;
  logic               pop;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level == LVLW'(DEPTH));
  assign rd_valid = (level != '0);
  assign pop      = rd_valid && pop_ready;
  assign rd_entry = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= ptr_next(wp);
      if (pop)  rp <= ptr_next(rp);
      level <= level + LVLW'(push) - LVLW'(pop);
    end
  end

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVLW'(DEPTH));

  // R6
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/txq_watermark.sv
module txq_watermark
  import txq_pkg::*;
#(
  parameter int unsigned LVLW  = 10,
  parameter int unsigned MARKS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LVLW-1:0]            level,
  input  logic [MARKS-1:0][LVLW-1:0] thr,
  output logic [MARKS-1:0]           mark_n
);
  for (genvar g = 0; g < MARKS; g++) begin : g_mark
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mark_n[g] <= 1'b1;
      else        mark_n[g] <= !above(32'(level), 32'(thr[g]));
    end

    // R9
    mark_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mark_n[g]) |-> ($past(level) > $past(thr[g])));

    // R9
    mark_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mark_n[g]) |-> ($past(level) <= $past(thr[g])));
  end
endmodule

// File: rtl/txq_ingress.sv
module txq_ingress
  import txq_pkg::*;
#(
  parameter  int unsigned DEPTH = 512,
  localparam int unsigned LVLW  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_n,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [LANES-1:0]   wr_lanes,
  input  logic               wr_sof,
  input  logic               wr_eof,
  input  logic               err_clr,
  input  logic [LVLW-1:0]    thr_a,
  input  logic [LVLW-1:0]    thr_b,
  input  logic               rd_ready,
  output logic               rd_valid,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic               mark_a_n,
  output logic               mark_b_n,
  output logic               lane_err,
  output logic               frame_err,
  output logic               ovf_err
);
  logic                 full, store;
  logic [LVLW-1:0]      level;
  logic [1:0]           marks_n;
  logic [1:0][LVLW-1:0] thr_vec;
  txq_entry_t           in_entry;

  assign in_entry = '{data: wr_data, lanes: wr_lanes, sof: wr_sof, eof: wr_eof};
  assign thr_vec  = {thr_b, thr_a};
  assign mark_a_n = marks_n[0];
  assign mark_b_n = marks_n[1];

  txq_frame_check u_check (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .sof(wr_sof), .eof(wr_eof),
    .lanes(wr_lanes), .full(full), .err_clr(err_clr), .store(store),
    .lane_err(lane_err), .frame_err(frame_err), .ovf_err(ovf_err)
  );

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(store), .push_entry(in_entry),
    .pop_ready(rd_ready), .full(full), .rd_valid(rd_valid),
    .rd_entry(rd_entry), .level(level)
  );

  txq_watermark #(.LVLW(LVLW), .MARKS(2)) u_marks (
    .clk(clk), .rst_n(rst_n), .level(level), .thr(thr_vec), .mark_n(marks_n)
  );

  // R1
  store_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_n |-> !store);
endmodule

// File: tb/txq_ingress_bench.sv
module txq_ingress_bench;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned LVLW  = $clog2(DEPTH + 1);

  typedef struct packed {
    logic        en_n;
    logic        sof;
    logic        eof;
    logic [3:0]  be;
    logic [31:0] d;
    logic        keep;
    logic        ferr;
    logic        lerr;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{1'b0, 1'b1, 1'b0, 4'hF, 32'hA0A0_0000, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 4'h0, 32'hA1A1_1111, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 4'h3, 32'hA2A2_2222, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 4'hF, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 4'h1, 32'hB4B4_4444, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 4'h0, 32'hC5C5_5555, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b1, 4'h8, 32'hD6D6_6666, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 4'hC, 32'hE7E7_7777, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 4'hF, 32'hF8F8_8888, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b1, 4'h0, 32'h0909_9999, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b1, 4'h2, 32'h1A1A_AAAA, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en_n = 1'b1, wr_sof = 1'b0, wr_eof = 1'b0, err_clr = 1'b0, rd_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_lanes = '0;
  logic [LVLW-1:0] thr_a = LVLW'(15), thr_b = LVLW'(15);
  logic rd_valid, mark_a_n, mark_b_n, lane_err, frame_err, ovf_err;
  logic [37:0] rd_entry;

  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [37:0] expq [16];
  int nexp = 0;

  always #5 clk = ~clk;

  txq_ingress #(.DEPTH(DEPTH)) u_txq_ingress (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .wr_lanes(wr_lanes), .wr_sof(wr_sof), .wr_eof(wr_eof), .err_clr(err_clr),
    .thr_a(thr_a), .thr_b(thr_b), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_entry(rd_entry), .mark_a_n(mark_a_n), .mark_b_n(mark_b_n),
    .lane_err(lane_err), .frame_err(frame_err), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic en_n, input logic s, input logic e, input logic [3:0] be, input logic [31:0] d);
    wr_en_n = en_n; wr_sof = s; wr_eof = e; wr_lanes = be; wr_data = d;
    @(negedge clk);
    wr_en_n = 1'b1; wr_sof = 1'b0; wr_eof = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int cnt;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    chk(!rd_valid, "R10 empty", rd_valid, 0);
    chk(mark_a_n && mark_b_n, "R10 marks", {mark_a_n, mark_b_n}, 2'b11);
    chk({lane_err, frame_err, ovf_err} == 3'b000, "R10 flags", {lane_err, frame_err, ovf_err}, 0);

    // Table walk: R1 R3 R4 R5 R7
    for (int i = 0; i < 11; i++) begin
      put(VEC[i].en_n, VEC[i].sof, VEC[i].eof, VEC[i].be, VEC[i].d);
      chk(frame_err == VEC[i].ferr, $sformatf("R5 vec %0d", i), frame_err, VEC[i].ferr);
      chk(lane_err == VEC[i].lerr, $sformatf("R4 R7 vec %0d", i), lane_err, VEC[i].lerr);
      if (VEC[i].keep) begin
        expq[nexp] = {VEC[i].d, VEC[i].be, VEC[i].sof, VEC[i].eof};
        nexp++;
      end
    end

    // R2 R8 drain in order, R1 R3 contents
    rd_ready = 1'b1;
    for (int k = 0; k < nexp; k++) begin
      chk(rd_valid && rd_entry == expq[k], $sformatf("R2 R8 entry %0d", k), rd_entry, expq[k]);
      @(negedge clk);
    end
    chk(!rd_valid, "R1 R8 nothing extra stored", rd_valid, 0);
    rd_ready = 1'b0;

    // R7 clear
    err_clr = 1'b1; idle(1); err_clr = 1'b0;
    chk({lane_err, frame_err} == 2'b00, "R7 clear", {lane_err, frame_err}, 0);

    // R5 start while open
    put(1'b0, 1'b1, 1'b0, 4'hF, 32'h1);
    chk(!frame_err, "R5 first start", frame_err, 0);
    put(1'b0, 1'b1, 1'b0, 4'hF, 32'h2);
    chk(frame_err, "R5 start while open", frame_err, 1);
    // R7 new error wins over clear in same cycle
    err_clr = 1'b1;
    put(1'b0, 1'b0, 1'b1, 4'h0, 32'h3);
    err_clr = 1'b0;
    chk(lane_err, "R7 set beats clear", lane_err, 1);
    put(1'b0, 1'b0, 1'b1, 4'hF, 32'h4);
    chk(frame_err == 1'b0, "R5 end closes open packet no error", frame_err, 0);
    err_clr = 1'b1; idle(1); err_clr = 1'b0;
    rd_ready = 1'b1; idle(3); rd_ready = 1'b0;
    chk(!rd_valid, "R5 three stored", rd_valid, 0);

    // R9 watermarks
    thr_a = LVLW'(2); thr_b = LVLW'(5);
    idle(1);
    for (int k = 0; k < 3; k++) put(1'b0, 1'b0, 1'b0, 4'hF, 32'h100 + k);
    chk(mark_a_n, "R9 mark_a lags one cycle", mark_a_n, 1);
    idle(1);
    chk(!mark_a_n && mark_b_n, "R9 mark_a low", {mark_a_n, mark_b_n}, 2'b01);
    for (int k = 0; k < 3; k++) put(1'b0, 1'b0, 1'b0, 4'hF, 32'h200 + k);
    chk(mark_b_n, "R9 mark_b lags one cycle", mark_b_n, 1);
    idle(1);
    chk(!mark_b_n, "R9 mark_b low at 6", mark_b_n, 0);
    rd_ready = 1'b1;
    put(1'b0, 1'b0, 1'b0, 4'hF, 32'h300);
    rd_ready = 1'b0;
    idle(1);
    chk(!mark_b_n, "R9 write+read keeps level", mark_b_n, 0);
    rd_ready = 1'b1; idle(1); rd_ready = 1'b0;
    chk(!mark_b_n, "R9 rise lags one cycle", mark_b_n, 0);
    idle(1);
    chk(mark_b_n, "R9 mark_b high at 5", mark_b_n, 1);

    // R6 overflow: level is 5, fill to 16
    for (int k = 0; k < 11; k++) put(1'b0, 1'b0, 1'b0, 4'hF, 32'h400 + k);
    chk(!ovf_err, "R6 no overflow at depth", ovf_err, 0);
    rd_ready = 1'b1;
    put(1'b0, 1'b0, 1'b0, 4'hF, 32'hBAD0_0000);
    rd_ready = 1'b0;
    chk(ovf_err, "R6 write while full with read", ovf_err, 1);
    cnt = 0;
    rd_ready = 1'b1;
    for (int k = 0; k < 40; k++) begin
      if (rd_valid) begin
        if (rd_entry[37:6] == 32'hBAD0_0000) cnt = cnt + 100;
        cnt++;
      end
      @(negedge clk);
    end
    rd_ready = 1'b0;
    chk(cnt == 15, "R6 dropped word absent, 15 left", cnt, 15);
    chk(ovf_err, "R7 overflow sticky", ovf_err, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule